// File: doc/BRIEF.md
# Serial Byte Readout with Clocked and Self-Timed Modes

This block sits between a character receiver and a host processor. An upstream stage delivers a finished 8-bit character on a parallel bus with a one-cycle load strobe. The block captures the character in a shift register, drives an active-low interrupt low to say a character is waiting, and then sends the character out on a single serial line.

A configuration input picks the output mode. In clocked mode the host drives an active-low shift clock: each falling edge of that clock puts the next bit on the line and the host samples on the rising edge. In self-timed mode the block frames the character itself as start-stop data, with the bit period set by a divider of the system clock. The default divider of 1024 gives 1200 baud from a 1.2288 MHz clock. A read-select input, active low, allows readout. The interrupt is released on a different event in each mode, and a character that arrives before the previous one has been read out replaces it and raises an overrun flag.

Top module: `serial_byte_readout`

## Requirements
- R1: After reset `serOut` is 1, `irqN` is 1 and `overrun` is 0.
- R2: In the cycle after `loadStrobe` is sampled high, `irqN` is 0 and `serOut` is 1. Any readout in progress is abandoned and the new character is the one sent next.
- R3: While `readSelN` is 1, no readout starts and edges on `hostClkN` have no effect. The line stays 1 and `irqN` stays 0 while a character waits.
- R4: With `syncMode` = 1 (clocked mode), each falling edge of `hostClkN` drives the next bit onto `serOut`, bit 0 first and bit 7 last. The bit appears within 3 system clocks of the edge, because the clock is synchronised first.
- R5: In clocked mode, `irqN` returns to 1 on the first rising edge of `hostClkN` after the readout has begun.
- R6: In clocked mode, the rising edge of `hostClkN` that follows bit 7 ends the readout and `serOut` returns to 1. After that, further host clock edges change neither `serOut` nor `irqN`.
- R7: With `syncMode` = 0 (self-timed mode) and `readSelN` = 0, a waiting character is sent at once as one low start bit, then data bits 0 to 7, then one high stop bit. Each bit lasts `BAUD_DIV` system clocks.
- R8: In self-timed mode, `irqN` stays 0 through the data bits and returns to 1 in the same cycle that the stop bit begins.
- R9: A load while a character is still pending sets `overrun` to 1. A load when nothing is pending clears `overrun` to 0. `overrun` changes only on a load.
- R10: `serOut` is 1 whenever no bit is being sent, including between readouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStrobe | input | 1 | One-cycle strobe that captures `loadData` |
| loadData | input | DATA_W | Received character |
| readSelN | input | 1 | Read select, 0 allows readout |
| syncMode | input | 1 | Output mode: 1 clocked by host, 0 self-timed |
| hostClkN | input | 1 | Active-low host shift clock, asynchronous |
| serOut | output | 1 | Serial data line, idles high |
| irqN | output | 1 | Active-low data-ready interrupt |
| overrun | output | 1 | Set when a pending character was replaced |

## Verification
The assertions assume that `syncMode` does not change while a readout is in progress. This matters because the check tying the interrupt release to the stop bit reads the current mode. They also assume that `loadStrobe` is a synchronous pulse. The bench holds the mode fixed from each load until that character has been read out, and changes it only between characters. The host clock is toggled with half periods of eight system clocks, well above the synchroniser delay, so no edge is lost or merged. Random characters and modes are mixed with forced back-to-back loads for overrun, plus directed cases for read select held high and for host edges after completion.

// File: rtl/serout_pkg.sv
package serout_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READY,
    ST_SYNC,
    ST_ASTART,
    ST_ADATA,
    ST_ASTOP
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture new character, line high
    logic shiftOut;  // put next bit on the line
    logic startBit;  // drive start bit
    logic stopBit;   // drive stop bit
    logic markIdle;  // return line to idle
    logic baudRun;   // let the bit timer count
  } dpCtl_t;

endpackage

// File: rtl/serout_edge_sync.sv
module serout_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineN,
  output logic risePulse,
  output logic fallPulse
);

  logic [STAGES-1:0] syncQ;
  logic              prevQ;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= lineN;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[STAGES-2:0], lineN};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= syncQ[STAGES-1];
  end

  assign risePulse = !prevQ && syncQ[STAGES-1];
  assign fallPulse = prevQ && !syncQ[STAGES-1];

endmodule

// File: rtl/serout_datapath.sv
module serout_datapath
  import serout_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int BAUD_DIV = 1024,
  localparam int CNT_W   = $clog2(DATA_W + 1),
  localparam int BAUD_W  = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [DATA_W-1:0] loadData,
  output logic              serOut,
  output logic              baudTick,
  output logic [CNT_W-1:0]  bitCount
);

  localparam logic [BAUD_W-1:0] BAUD_LAST = BAUD_W'(BAUD_DIV - 1);

  logic [DATA_W-1:0] shiftQ;
  logic              lineQ;
  logic [CNT_W-1:0]  bitCntQ;
  logic [BAUD_W-1:0] baudCntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftQ <= '0;
    else if (ctl.load)     shiftQ <= loadData;
    else if (ctl.shiftOut) shiftQ <= shiftQ >> 1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    lineQ <= 1'b1;
    else if (ctl.load)                            lineQ <= 1'b1;
    else if (ctl.startBit)                        lineQ <= 1'b0;
    else if (ctl.shiftOut)                        lineQ <= shiftQ[0];
    else if (ctl.stopBit || ctl.markIdle)         lineQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             bitCntQ <= '0;
    else if (ctl.load)     bitCntQ <= '0;
    else if (ctl.shiftOut) bitCntQ <= bitCntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                baudCntQ <= '0;
    else if (!ctl.baudRun || ctl.load)        baudCntQ <= '0;
    else if (baudCntQ == BAUD_LAST)           baudCntQ <= '0;
    else                                      baudCntQ <= baudCntQ + 1'b1;
  end

  assign baudTick = ctl.baudRun && (baudCntQ == BAUD_LAST);
  assign serOut   = lineQ;
  assign bitCount = bitCntQ;

endmodule

// File: rtl/serout_control.sv
module serout_control
  import serout_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int CNT_W  = $clog2(DATA_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStrobe,
  input  logic             readSelN,
  input  logic             syncMode,
  input  logic             hostRise,
  input  logic             hostFall,
  input  logic             baudTick,
  input  logic [CNT_W-1:0] bitCount,
  output dpCtl_t           ctl,
  output logic             irqN,
  output logic             overrun
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  rdState_t stQ, stNext;
  logic     irqRelease;
  logic     irqQ;
  logic     ovrQ;
  logic     readEn;

  assign readEn = !readSelN;

  always_comb begin
    ctl        = '0;
    stNext     = stQ;
    irqRelease = 1'b0;
    if (loadStrobe) begin
      ctl.load = 1'b1;
      stNext   = ST_READY;
    end else begin
      unique case (stQ)
        ST_READY: begin
          if (readEn) begin
            if (syncMode) begin
              if (hostFall) begin
                ctl.shiftOut = 1'b1;
                stNext       = ST_SYNC;
              end
            end else begin
              ctl.startBit = 1'b1;
              stNext       = ST_ASTART;
            end
          end
        end
        ST_SYNC: begin
          if (readEn) begin
            if (hostFall && (bitCount != LAST_CNT)) begin
              ctl.shiftOut = 1'b1;
            end else if (hostRise) begin
              irqRelease = 1'b1;
              if (bitCount == LAST_CNT) begin
                ctl.markIdle = 1'b1;
                stNext       = ST_IDLE;
              end
            end
          end
        end
        ST_ASTART: begin
          ctl.baudRun = 1'b1;
          if (baudTick) begin
            ctl.shiftOut = 1'b1;
            stNext       = ST_ADATA;
          end
        end
        ST_ADATA: begin
          ctl.baudRun = 1'b1;
          if (baudTick) begin
            if (bitCount == LAST_CNT) begin
              ctl.stopBit = 1'b1;
              irqRelease  = 1'b1;
              stNext      = ST_ASTOP;
            end else begin
              ctl.shiftOut = 1'b1;
            end
          end
        end
        ST_ASTOP: begin
          ctl.baudRun = 1'b1;
          if (baudTick) begin
            ctl.markIdle = 1'b1;
            stNext       = ST_IDLE;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= ST_IDLE;
    else       stQ <= stNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           irqQ <= 1'b1;
    else if (loadStrobe) irqQ <= 1'b0;
    else if (irqRelease) irqQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ovrQ <= 1'b0;
    else if (loadStrobe) ovrQ <= (stQ != ST_IDLE);
  end

  assign irqN    = irqQ;
  assign overrun = ovrQ;

endmodule

// File: rtl/serial_byte_readout.sv
module serial_byte_readout
  import serout_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BAUD_DIV    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStrobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              readSelN,
  input  logic              syncMode,
  input  logic              hostClkN,
  output logic              serOut,
  output logic              irqN,
  output logic              overrun
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  dpCtl_t           ctl;
  logic             hostRise;
  logic             hostFall;
  logic             baudTick;
  logic [CNT_W-1:0] bitCount;

  serout_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk       (clk),
    .rstN      (rstN),
    .lineN     (hostClkN),
    .risePulse (hostRise),
    .fallPulse (hostFall)
  );

  serout_control #(.DATA_W(DATA_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .readSelN   (readSelN),
    .syncMode   (syncMode),
    .hostRise   (hostRise),
    .hostFall   (hostFall),
    .baudTick   (baudTick),
    .bitCount   (bitCount),
    .ctl        (ctl),
    .irqN       (irqN),
    .overrun    (overrun)
  );

  serout_datapath #(.DATA_W(DATA_W), .BAUD_DIV(BAUD_DIV)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .loadData (loadData),
    .serOut   (serOut),
    .baudTick (baudTick),
    .bitCount (bitCount)
  );

endmodule

// File: rtl/serout_checker.sv
module serout_checker (
  input logic clk,
  input logic rstN,
  input logic loadStrobe,
  input logic syncMode,
  input logic serOut,
  input logic irqN,
  input logic overrun
);

  // R2
  irq_low_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> !irqN);

  // R2
  line_high_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> serOut);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && !irqN) |=> overrun);

  // R9
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> $stable(overrun));

  // R8
  stop_with_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqN) && !syncMode) |-> serOut);

endmodule

bind serial_byte_readout serout_checker chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .loadStrobe (loadStrobe),
  .syncMode   (syncMode),
  .serOut     (serOut),
  .irqN       (irqN),
  .overrun    (overrun)
);

// File: tb/serial_byte_readout_test.sv
module serial_byte_readout_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 20;
  localparam int HALF_HOST  = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStrobe = 1'b0;
  logic [7:0] loadData = '0;
  logic       readSelN = 1'b0;
  logic       syncMode = 1'b1;
  logic       hostClkN = 1'b1;
  logic       serOut;
  logic       irqN;
  logic       overrun;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_byte_readout #(.DATA_W(8), .BAUD_DIV(DIV)) uut (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .loadData   (loadData),
    .readSelN   (readSelN),
    .syncMode   (syncMode),
    .hostClkN   (hostClkN),
    .serOut     (serOut),
    .irqN       (irqN),
    .overrun    (overrun)
  );

  function automatic int bitOf(input logic [7:0] d, input int i);
    return int'(d[i]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic loadByte(input logic [7:0] d);
    @(negedge clk);
    loadStrobe = 1'b1;
    loadData   = d;
    @(negedge clk);
    loadStrobe = 1'b0;
    chk("R2 irq low after load", int'(irqN), 0);
    chk("R2 line high after load", int'(serOut), 1);
  endtask

  task automatic syncRead(input logic [7:0] exp);
    chk("R5 irq low before host clock", int'(irqN), 0);
    for (int i = 0; i < 8; i++) begin
      hostClkN = 1'b0;
      waitNeg(HALF_HOST);
      chk("R4 clocked data bit", int'(serOut), bitOf(exp, i));
      hostClkN = 1'b1;
      waitNeg(HALF_HOST);
      if (i == 0) chk("R5 irq high after first rise", int'(irqN), 1);
    end
    chk("R6 line idle after bit 7", int'(serOut), 1);
  endtask

  task automatic asyncRead(input logic [7:0] exp);
    int guard = 0;
    while (serOut !== 1'b0 && guard < 4*DIV) begin
      @(negedge clk);
      guard++;
    end
    chk("R7 start bit seen", int'(serOut), 0);
    waitNeg(DIV/2);
    chk("R7 start bit mid", int'(serOut), 0);
    for (int i = 0; i < 8; i++) begin
      waitNeg(DIV);
      chk("R7 framed data bit", int'(serOut), bitOf(exp, i));
      if (i == 7) chk("R8 irq low during data", int'(irqN), 0);
    end
    waitNeg(DIV);
    chk("R7 stop bit high", int'(serOut), 1);
    chk("R8 irq high in stop bit", int'(irqN), 1);
    waitNeg(DIV);
    chk("R10 line idle after frame", int'(serOut), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    waitNeg(3);
    chk("R1 reset line", int'(serOut), 1);
    chk("R1 reset irq", int'(irqN), 1);
    chk("R1 reset overrun", int'(overrun), 0);
    rstN = 1'b1;
    waitNeg(2);

    // directed clocked readout
    syncMode = 1'b1;
    loadByte(8'hA5);
    chk("R9 clean load", int'(overrun), 0);
    syncRead(8'hA5);
    // R6: extra host edges after completion
    hostClkN = 1'b0; waitNeg(HALF_HOST);
    chk("R6 no bit after done", int'(serOut), 1);
    hostClkN = 1'b1; waitNeg(HALF_HOST);
    chk("R6 irq stays high", int'(irqN), 1);

    // R3: read select high blocks clocked readout
    readSelN = 1'b1;
    loadByte(8'h3C);
    for (int i = 0; i < 3; i++) begin
      hostClkN = 1'b0; waitNeg(HALF_HOST);
      hostClkN = 1'b1; waitNeg(HALF_HOST);
    end
    chk("R3 line held while deselected", int'(serOut), 1);
    chk("R3 irq held while deselected", int'(irqN), 0);
    readSelN = 1'b0;
    waitNeg(2);
    syncRead(8'h3C);

    // R3: read select high blocks self-timed readout
    readSelN = 1'b1;
    syncMode = 1'b0;
    loadByte(8'h81);
    chk("R9 load after full read", int'(overrun), 0);
    waitNeg(3*DIV);
    chk("R3 no frame while deselected", int'(serOut), 1);
    chk("R3 irq pending while deselected", int'(irqN), 0);
    readSelN = 1'b0;
    asyncRead(8'h81);

    // R9: overrun by back-to-back loads, second byte wins
    loadByte(8'h11);
    loadByte(8'hE7);
    chk("R9 overrun set", int'(overrun), 1);
    asyncRead(8'hE7);
    syncMode = 1'b1;
    loadByte(8'h00);
    chk("R9 overrun cleared", int'(overrun), 0);
    syncRead(8'h00);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic doOvr;
      d        = 8'($urandom);
      syncMode = 1'($urandom);
      doOvr    = ($urandom % 4) == 0;
      if (doOvr) loadByte(8'($urandom));
      loadByte(d);
      chk("R9 overrun random", int'(overrun), int'(doOvr));
      if (syncMode) syncRead(d);
      else          asyncRead(d);
      waitNeg(4);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule